// File: doc/BRIEF.md
# Serially Programmed PLL Divider Core

This block holds the digital half of a frequency synthesizer. A fixed counter divides the reference clock (nominally 13.2 MHz) by 2112 to produce a 6.25 kHz comparison pulse. A programmable counter divides the prescaled oscillator feedback (around 3.5 MHz) down to the same rate. Each unit of the programmed divisor therefore moves the oscillator target by one comparison step of 6.25 kHz. A two-flop phase-frequency detector turns the two pulse trains into up and down pump pulses. A lock monitor watches the width of those pulses.

The divisor arrives over a three-wire port with data, clock and latch lines. Bits collect in a holding shift register and reach the divider only when the latch line is high. The divider then adopts the new value at its next wrap, so a count in progress is never cut short. A transmit request passes to the transmit enable only while the loop is locked.

Everything runs on the reference clock. The feedback and serial clock inputs are sampled and edge detected in that domain, so each must stay high and low for at least two reference clocks.

Top module: `pll_synth_core`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `ref_cmp`, `fb_cmp`, `pump_up`, `pump_dn`, `lock` and `tx_en` are 0. The active feedback divisor after reset is 2.
- R2: `ref_cmp` is a single-cycle pulse that repeats exactly every REF_DIV (default 2112) clock cycles.
- R3: On each rising edge of `ser_clk`, the value of `ser_data` is shifted into the holding register. The first bit received becomes the most significant of the 16. Shifting alone leaves the feedback divisor unchanged.
- R4: While `ser_le` is high, the holding register is copied into the programmed word.
- R5: `fb_cmp` is a single-cycle pulse issued once per N rising edges of `fb_in`, where N is the active divisor.
- R6: A newly latched word becomes the active divisor only at the next feedback terminal count. The interval in progress completes with the old divisor.
- R7: A latched word of 0 or 1 is used as a divisor of 2.
- R8: `pump_up` rises the cycle after a `ref_cmp` pulse, and `pump_dn` rises the cycle after a `fb_cmp` pulse.
- R9: When `pump_up` and `pump_dn` are both high and no new comparison pulse arrives, both are low in the next cycle.
- R10: At each `ref_cmp` pulse, the monitor judges the window just ended. A window is good when its count of cycles with exactly one pump output high is below `lock_thr`. `lock` rises after 16 consecutive good windows and falls after the first window that is not good.
- R11: `tx_en` equals `tx_req` AND `lock`, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_in | input | 1 | Prescaled oscillator feedback clock |
| ser_clk | input | 1 | Serial port bit clock |
| ser_data | input | 1 | Serial port data, first bit is the MSB |
| ser_le | input | 1 | Serial port latch line |
| tx_req | input | 1 | Transmit request |
| lock_thr | input | THR_W (8) | Pump pulse width limit per window, in clocks |
| ref_cmp | output | 1 | Divided reference comparison pulse |
| fb_cmp | output | 1 | Divided feedback comparison pulse |
| pump_up | output | 1 | Detector up output |
| pump_dn | output | 1 | Detector down output |
| lock | output | 1 | Lock indication |
| tx_en | output | 1 | Lock-qualified transmit enable |

## Verification
A rise on `fb_in` passes through two sampling flops before it is counted. The `fb_cmp` pulse that closes an interval therefore appears two clocks after the last edge of that interval, always before the next edge. The bench counts feedback edges between pulses and compares each count against divisors it queued when it programmed the port. A pump output rises one clock after its comparison pulse and clears one clock after both are high; the bench samples exactly those cycles after seeing the pulse. `lock` changes one clock after a `ref_cmp`, so lock checks are made at sampled points that lie whole comparison periods after the feedback starts. `tx_en` is checked in the same sample as `lock` and again one clock after `tx_req` changes.

// File: rtl/pll_synth_pkg.sv
package pll_synth_pkg;

    // Defaults shared by the core and its sub-blocks
    parameter int WORD_W_D   = 16;
    parameter int REF_DIV_D  = 2112;
    parameter int LOCK_RUN_D = 16;
    parameter int THR_W_D    = 8;
    parameter int MIN_DIV    = 2;

    // Charge pump request pair
    typedef struct packed {
        logic up;
        logic dn;
    } pump_t;

    // Lock monitor state
    typedef enum logic {
        LK_SEARCH = 1'b0,
        LK_HELD   = 1'b1
    } lock_st_e;

    // Saturating increment for an 8..32 bit counter held in an int-sized slot
    function automatic int sat_inc(input int v, input int max_v);
        return (v >= max_v) ? max_v : v + 1;
    endfunction

endpackage

// File: rtl/pll_divider.sv
module pll_divider #(
    parameter int W       = 16,
    parameter int RST_DIV = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] div_in,
    output logic         tc
);

    logic [W-1:0] cnt;
    logic [W-1:0] div_cur;

    // Counts step events; the divisor is reloaded only when the count wraps
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            div_cur <= W'(RST_DIV);
            tc      <= 1'b0;
        end else begin
            tc <= 1'b0;
            if (step) begin
                if (cnt == div_cur - W'(1)) begin
                    cnt     <= '0;
                    div_cur <= div_in;
                    tc      <= 1'b1;
                end else begin
                    cnt <= cnt + W'(1);
                end
            end
        end
    end

    // R5: position never reaches the active divisor
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt < div_cur);

    // R2: terminal pulses are isolated single cycles
    assert_tc_single_R2: assert property (@(posedge clk) disable iff (rst)
        tc |=> !tc);

    // R6: the divisor only moves at a wrap
    assert_div_at_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(div_cur) |-> tc);

endmodule

// File: rtl/pll_serial_port.sv
module pll_serial_port #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_clk,
    input  logic         ser_data,
    input  logic         ser_le,
    output logic [W-1:0] word
);

    logic         sclk_q;
    logic         sclk_q2;
    logic         sdat_q;
    logic         le_q;
    logic         bit_tick;
    logic [W-1:0] shreg;

    assign bit_tick = sclk_q & ~sclk_q2;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            sclk_q2 <= 1'b0;
            sdat_q  <= 1'b0;
            le_q    <= 1'b0;
            shreg   <= '0;
            word    <= '0;
        end else begin
            sclk_q  <= ser_clk;
            sclk_q2 <= sclk_q;
            sdat_q  <= ser_data;
            le_q    <= ser_le;
            if (bit_tick) begin
                shreg <= {shreg[W-2:0], sdat_q};
            end
            if (le_q) begin
                word <= shreg;
            end
        end
    end

    // R4: the programmed word changes only under the latch line
    assert_word_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(word) |-> $past(le_q));

endmodule

// File: rtl/pll_pfd_lock.sv
module pll_pfd_lock
    import pll_synth_pkg::*;
#(
    parameter int THR_W    = 8,
    parameter int LOCK_RUN = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_ev,
    input  logic             fb_ev,
    input  logic [THR_W-1:0] thr,
    output logic             up,
    output logic             dn,
    output logic             lock
);

    localparam int RUN_W = (LOCK_RUN > 2) ? $clog2(LOCK_RUN) : 1;
    localparam int ERR_MAX = (1 << THR_W) - 1;

    pump_t            pump;
    lock_st_e         st;
    logic [THR_W-1:0] err;
    logic [RUN_W-1:0] run;
    logic             window_ok;

    assign up = pump.up;
    assign dn = pump.dn;
    assign lock = (st == LK_HELD);
    assign window_ok = (err < thr);

    // Two-flop detector; both set clears both on the following cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            pump <= '0;
        end else if (pump.up && pump.dn) begin
            pump.up <= ref_ev;
            pump.dn <= fb_ev;
        end else begin
            pump.up <= pump.up | ref_ev;
            pump.dn <= pump.dn | fb_ev;
        end
    end

    // Window judge: error width measured between reference pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            err <= '0;
            run <= '0;
            st  <= LK_SEARCH;
        end else if (ref_ev) begin
            err <= '0;
            if (window_ok) begin
                if (run == RUN_W'(LOCK_RUN - 1)) begin
                    st <= LK_HELD;
                end else begin
                    run <= run + RUN_W'(1);
                end
            end else begin
                run <= '0;
                st  <= LK_SEARCH;
            end
        end else if (pump.up ^ pump.dn) begin
            err <= THR_W'(sat_inc(int'(err), ERR_MAX));
        end
    end

    // R8: an up request only starts from a reference pulse
    assert_up_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(up) |-> $past(ref_ev));

    // R9: coincident outputs reset each other
    assert_pump_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (up && dn && !ref_ev && !fb_ev) |=> (!up && !dn));

    // R10: lock only appears at a window boundary
    assert_lock_rise_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> $past(ref_ev));

    // R10: a wide window removes lock at once
    assert_lock_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (ref_ev && !window_ok) |=> !lock);

endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core
    import pll_synth_pkg::*;
#(
    parameter int WORD_W   = WORD_W_D,
    parameter int REF_DIV  = REF_DIV_D,
    parameter int LOCK_RUN = LOCK_RUN_D,
    parameter int THR_W    = THR_W_D
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fb_in,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_le,
    input  logic             tx_req,
    input  logic [THR_W-1:0] lock_thr,
    output logic             ref_cmp,
    output logic             fb_cmp,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             lock,
    output logic             tx_en
);

    localparam int REF_W = $clog2(REF_DIV + 1);

    logic              fb_q;
    logic              fb_q2;
    logic              fb_step;
    logic [WORD_W-1:0] word_raw;
    logic [WORD_W-1:0] fb_div;

    // Feedback edge detection in the reference domain
    always_ff @(posedge clk) begin
        if (rst) begin
            fb_q  <= 1'b0;
            fb_q2 <= 1'b0;
        end else begin
            fb_q  <= fb_in;
            fb_q2 <= fb_q;
        end
    end

    assign fb_step = fb_q & ~fb_q2;

    pll_serial_port #(.W(WORD_W)) u_port (
        .clk      (clk),
        .rst      (rst),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_le   (ser_le),
        .word     (word_raw)
    );

    // Divisors below the minimum would stall the counter
    assign fb_div = (word_raw < WORD_W'(MIN_DIV)) ? WORD_W'(MIN_DIV) : word_raw;

    pll_divider #(.W(REF_W), .RST_DIV(REF_DIV)) u_ref_div (
        .clk    (clk),
        .rst    (rst),
        .step   (1'b1),
        .div_in (REF_W'(REF_DIV)),
        .tc     (ref_cmp)
    );

    pll_divider #(.W(WORD_W), .RST_DIV(MIN_DIV)) u_fb_div (
        .clk    (clk),
        .rst    (rst),
        .step   (fb_step),
        .div_in (fb_div),
        .tc     (fb_cmp)
    );

    pll_pfd_lock #(.THR_W(THR_W), .LOCK_RUN(LOCK_RUN)) u_pfd (
        .clk    (clk),
        .rst    (rst),
        .ref_ev (ref_cmp),
        .fb_ev  (fb_cmp),
        .thr    (lock_thr),
        .up     (pump_up),
        .dn     (pump_dn),
        .lock   (lock)
    );

    assign tx_en = tx_req & lock;

endmodule

// File: tb/test_pll_synth_core.sv
module test_pll_synth_core;

    localparam int CLK_PERIOD = 10;
    localparam int REF_N      = 2112;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fb_in = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_le = 1'b0;
    logic       tx_req = 1'b1;
    logic [7:0] lock_thr = 8'd40;
    logic       ref_cmp, fb_cmp, pump_up, pump_dn, lock, tx_en;

    pll_synth_core i_pll_synth_core (
        .clk      (clk),
        .rst      (rst),
        .fb_in    (fb_in),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_le   (ser_le),
        .tx_req   (tx_req),
        .lock_thr (lock_thr),
        .ref_cmp  (ref_cmp),
        .fb_cmp   (fb_cmp),
        .pump_up  (pump_up),
        .pump_dn  (pump_dn),
        .lock     (lock),
        .tx_en    (tx_en)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    int exp_q[$];
    bit sb_on = 1'b0;
    bit fb_free = 1'b0;
    int fb_rises = 0;
    bit fb_prev = 1'b0;
    int ref_gap = 0;
    bit ref_seen = 1'b0;
    int exp_val;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic sample();
        @(posedge clk);
        #(CLK_PERIOD / 4);
    endtask

    task automatic wait_ref();
        do sample(); while (!ref_cmp);
    endtask

    task automatic wait_fb();
        do sample(); while (!fb_cmp);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic fb_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) fb_in = 1'b1;
            @(negedge clk);
            @(negedge clk) fb_in = 1'b0;
            @(negedge clk);
        end
    endtask

    // Sends a 16-bit word, first bit MSB, optionally followed by a latch pulse
    task automatic write_word(input int w, input bit do_latch);
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk) begin ser_data = w[i]; ser_clk = 1'b1; end
            @(negedge clk);
            @(negedge clk) ser_clk = 1'b0;
            @(negedge clk);
        end
        if (do_latch) begin
            @(negedge clk) ser_le = 1'b1;
            @(negedge clk);
            @(negedge clk) ser_le = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic latch_only();
        @(negedge clk) ser_le = 1'b1;
        @(negedge clk);
        @(negedge clk) ser_le = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Free-running feedback: period of four clocks
    initial begin
        forever begin
            @(negedge clk);
            if (fb_free) begin
                fb_in = 1'b1;
                @(negedge clk);
                @(negedge clk) fb_in = 1'b0;
                @(negedge clk);
            end
        end
    end

    // Monitor: reference spacing and feedback interval scoreboard
    initial begin
        forever begin
            sample();
            if (rst) begin
                fb_rises = 0;
                ref_gap  = 0;
                ref_seen = 1'b0;
                fb_prev  = fb_in;
            end else begin
                if (fb_in && !fb_prev) fb_rises++;
                fb_prev = fb_in;
                if (fb_cmp) begin
                    if (sb_on) begin
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R5", "fb_cmp with no expected interval", fb_rises, 0);
                        end else begin
                            exp_val = exp_q.pop_front();
                            check(fb_rises == exp_val, "R5 R6 R7",
                                  "feedback edges per fb_cmp", fb_rises, exp_val);
                        end
                    end
                    fb_rises = 0;
                end
                ref_gap++;
                if (ref_cmp) begin
                    if (ref_seen) check(ref_gap == REF_N, "R2", "ref_cmp spacing", ref_gap, REF_N);
                    ref_seen = 1'b1;
                    ref_gap  = 0;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=%0d expected=%0d", WATCHDOG, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (2) @(negedge clk);
        sample();
        check(ref_cmp == 0 && fb_cmp == 0, "R1", "compare pulses in reset", ref_cmp | fb_cmp, 0);
        check(pump_up == 0 && pump_dn == 0, "R1", "pump outputs in reset", pump_up | pump_dn, 0);
        @(negedge clk) rst = 1'b0;
        sample();
        check(lock == 0, "R1", "lock after reset", lock, 0);
        check(tx_en == 0, "R1", "tx_en after reset with request high", tx_en, 0);
        check(pump_up == 0 && pump_dn == 0, "R1", "pumps after reset", pump_up | pump_dn, 0);

        // R1 reset divisor 2, R5 interval counting
        sb_on = 1'b1;
        exp_q.push_back(2); exp_q.push_back(2);
        fb_pulses(4);

        // R3 shifting without latch changes nothing
        write_word(6, 1'b0);
        exp_q.push_back(2); exp_q.push_back(2);
        fb_pulses(4);

        // R4 latch, R6 old divisor finishes first
        latch_only();
        exp_q.push_back(2); exp_q.push_back(6); exp_q.push_back(6);
        fb_pulses(14);

        // R6 word latched in the middle of a count; R3 MSB first (9 not 0x9000)
        fb_pulses(2);
        write_word(9, 1'b1);
        exp_q.push_back(6); exp_q.push_back(9);
        fb_pulses(13);

        // R7 word 0 clamps to 2
        write_word(0, 1'b1);
        exp_q.push_back(9); exp_q.push_back(2); exp_q.push_back(2);
        fb_pulses(13);

        // R7 word 1 clamps to 2
        write_word(1, 1'b1);
        exp_q.push_back(2); exp_q.push_back(2); exp_q.push_back(2);
        fb_pulses(6);

        // R3 upper byte carried in MSB-first order
        write_word(16'h0103, 1'b1);
        exp_q.push_back(2); exp_q.push_back(259);
        fb_pulses(261);
        repeat (4) sample();
        check(exp_q.size() == 0, "R5", "expected intervals left over", exp_q.size(), 0);
        sb_on = 1'b0;
        exp_q.delete();

        // R8 down then R9 coincidence clear
        do_reset();
        fork fb_pulses(2); join_none
        wait_fb();
        sample();
        check(pump_dn == 1, "R8", "pump_dn one cycle after fb_cmp", pump_dn, 1);
        check(pump_up == 0, "R8", "pump_up stays low without ref_cmp", pump_up, 0);
        wait_ref();
        sample();
        check(pump_up == 1, "R8", "pump_up one cycle after ref_cmp", pump_up, 1);
        check(pump_dn == 1, "R9", "both pumps high before clear", pump_dn, 1);
        sample();
        check(pump_up == 0 && pump_dn == 0, "R9", "pumps cleared after coincidence",
              pump_up | pump_dn, 0);

        // R10 lock acquisition with matched divisor 528 (528 x 4 = 2112)
        lock_thr = 8'd40;
        tx_req = 1'b1;
        do_reset();
        write_word(528, 1'b1);
        wait_ref();
        fb_free = 1'b1;
        repeat (8) wait_ref();
        sample();
        check(lock == 0, "R10", "lock before 16 good windows", lock, 0);
        check(tx_en == 0, "R11", "tx_en while unlocked", tx_en, 0);
        repeat (12) wait_ref();
        sample();
        check(lock == 1, "R10", "lock after 16 good windows", lock, 1);
        check(tx_en == 1, "R11", "tx_en with lock and request", tx_en, 1);
        @(negedge clk) tx_req = 1'b0;
        sample();
        check(tx_en == 0, "R11", "tx_en follows dropped request", tx_en, 0);
        @(negedge clk) tx_req = 1'b1;
        sample();
        check(tx_en == 1, "R11", "tx_en follows restored request", tx_en, 1);

        // R10 frequency error removes lock
        write_word(600, 1'b1);
        repeat (4) wait_ref();
        sample();
        check(lock == 0, "R10", "lock after frequency step", lock, 0);
        check(tx_en == 0, "R11", "tx_en after lock loss", tx_en, 0);
        fb_free = 1'b0;

        // R10 threshold below the residual phase error never locks
        lock_thr = 8'd2;
        repeat (6) @(negedge clk);
        do_reset();
        write_word(528, 1'b1);
        wait_ref();
        fb_free = 1'b1;
        repeat (20) wait_ref();
        sample();
        check(lock == 0, "R10", "lock with tight threshold", lock, 0);
        fb_free = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule